// File: doc/BRIEF.md
# Negative-First 3D Route Computation Unit

This unit sits behind one input port of a seven-port router in a three-dimensional mesh. When a packet's head flit is presented, it takes the destination coordinates carried by that flit and compares them with the router's own X, Y and Z position. From that comparison it raises a one-hot request for exactly one output port. The request stays fixed until the packet's tail flit has been accepted. Every input port of the router has its own copy of the unit, so all seven inputs can resolve their routes in the same cycle.

The routing rule is a three-dimensional turn model rather than fixed dimension order. A packet first takes all the hops it needs in negative directions, and only then any hops in positive directions. Inside each group the dimensions are tried in a fixed order. Because of this, no legal path ever turns from a positive direction into a negative one. The unit also knows which input it serves, and it raises a flag if the port it has just chosen would make such a forbidden turn. At the faces of the mesh, a port that leads out of the mesh is never chosen.

Top module: `nf_route_unit`

## Requirements
- R1: `route_req` is one-hot or all zero. Its bits are: bit 0 local, bit 1 west (-x), bit 2 east (+x), bit 3 south (-y), bit 4 north (+y), bit 5 down (-z), bit 6 up (+z).
- R2: The destination is read from `hdr_dst`. X is in bits [CW-1:0], Y in [2*CW-1:CW] and Z in [3*CW-1:2*CW]. A route is computed, and shown on `route_req` in the same cycle, when `flit_valid` and `flit_bop` are high and no packet is in progress.
- R3: If the destination equals the router's coordinates in all three dimensions, the local port (bit 0) is requested.
- R4: If any dimension has a destination below the router coordinate, a negative-direction port is requested, whatever the positive needs are.
- R5: Among the negative needs, -x has the highest priority, then -z, then -y.
- R6: When there are no negative needs, the positive candidates are tried in the order +y, then +x, then +z. A dimension whose coordinate is already equal to the destination is skipped.
- R7: Once a head flit without `flit_eop` has been accepted (`flit_valid` and `flit_ready` both high), the request is held unchanged through stalls and later flits. A later `flit_bop` does not change it. In the cycle after the `flit_eop` flit is accepted, the request drops to zero, unless a new head flit is being presented in that cycle.
- R8: A single-flit packet (`flit_bop` and `flit_eop` together) drives the request only while that flit is presented. Nothing is held after it is accepted.
- R9: At the last coordinate of a dimension (mesh size minus one), the positive port of that dimension is never requested. A destination beyond that coordinate counts as no hop in that dimension.
- R10: `in_port` uses the bit numbering of R1. `turn_err` is high exactly when `in_port` is 1, 3 or 5 (the packet is moving in a positive direction) and the request is a negative port (bit 1, 3 or 5).
- R11: After reset, `route_req` and `turn_err` are zero while no flit is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | CW | Router X coordinate (static) |
| my_y | input | CW | Router Y coordinate (static) |
| my_z | input | CW | Router Z coordinate (static) |
| in_port | input | 3 | Index of the input port this unit serves (static) |
| flit_valid | input | 1 | A flit is presented |
| flit_ready | input | 1 | The presented flit is accepted this cycle |
| flit_bop | input | 1 | Presented flit is a head flit |
| flit_eop | input | 1 | Presented flit is a tail flit |
| hdr_dst | input | 3*CW | Destination coordinates of the head flit |
| route_req | output | 7 | One-hot output port request |
| turn_err | output | 1 | Request would turn from a positive to a negative direction |

## Verification
The hardest property to reach from the ports is the guarantee that covers a whole path. For every source and destination in the mesh, repeated decisions by the unit must reach the destination and never turn from positive to negative. A single decision is not enough to show this. To get there, the bench walks all 729 source and destination pairs in a 3x3x3 mesh hop by hop. At each hop it moves the unit's own coordinates to the neighbour that was chosen. It sets `in_port` to the port the packet arrives on, and it tracks the direction history itself. The hold behaviour is driven with a stray head marker in the middle of a packet and a stalled tail flit. The turn flag is provoked with a destination that a legal upstream router would never have sent on.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

    localparam int unsigned NUM_PORTS = 7;
    localparam int unsigned NUM_DIMS  = 3;

    // output port numbering: negative port of dimension d is 1+2d, positive is 2+2d
    localparam int unsigned PORT_LOCAL = 0;
    localparam int unsigned PORT_XN    = 1;
    localparam int unsigned PORT_XP    = 2;
    localparam int unsigned PORT_YN    = 3;
    localparam int unsigned PORT_YP    = 4;
    localparam int unsigned PORT_ZN    = 5;
    localparam int unsigned PORT_ZP    = 6;

    typedef logic [NUM_PORTS-1:0] port_vec_t;

    typedef struct packed {
        logic      busy;
        port_vec_t route;
    } rc_state_t;

    function automatic int unsigned neg_port(input int unsigned dim);
        return 1 + 2 * dim;
    endfunction

    function automatic int unsigned pos_port(input int unsigned dim);
        return 2 + 2 * dim;
    endfunction

endpackage

// File: rtl/nfr_dim_cmp.sv
module nfr_dim_cmp #(
    parameter int unsigned CW   = 2,
    parameter int unsigned MESH = 3
) (
    input  logic [CW-1:0] own_c,
    input  logic [CW-1:0] dst_c,
    output logic          need_neg,
    output logic          need_pos
);
    localparam logic [CW-1:0] LAST_C = CW'(MESH - 1);

    always_comb begin
        need_neg = (dst_c < own_c);
        // at the far face the positive link does not exist: treat as no hop
        need_pos = (dst_c > own_c) && (own_c != LAST_C);
    end

endmodule

// File: rtl/nfr_port_select.sv
module nfr_port_select
    import nfr_pkg::*;
(
    input  logic [NUM_DIMS-1:0] need_neg,
    input  logic [NUM_DIMS-1:0] need_pos,
    output port_vec_t           req
);
    // dimension indices: 0 = x, 1 = y, 2 = z
    localparam int unsigned NEG_ORDER [NUM_DIMS] = '{0, 2, 1};
    localparam int unsigned POS_ORDER [NUM_DIMS] = '{1, 0, 2};

    logic found;

    always_comb begin
        req   = '0;
        found = 1'b0;
        for (int k = 0; k < NUM_DIMS; k++) begin
            if (!found && need_neg[NEG_ORDER[k]]) begin
                req[neg_port(NEG_ORDER[k])] = 1'b1;
                found = 1'b1;
            end
        end
        for (int k = 0; k < NUM_DIMS; k++) begin
            if (!found && need_pos[POS_ORDER[k]]) begin
                req[pos_port(POS_ORDER[k])] = 1'b1;
                found = 1'b1;
            end
        end
        if (!found) begin
            req[PORT_LOCAL] = 1'b1;
        end
    end

endmodule

// File: rtl/nfr_turn_check.sv
module nfr_turn_check
    import nfr_pkg::*;
(
    input  logic [2:0] in_port,
    input  port_vec_t  req,
    output logic       turn_err
);
    logic moving_pos;
    logic going_neg;

    always_comb begin
        // arriving on a negative-side input means travelling in a positive direction
        moving_pos = (in_port == 3'(PORT_XN)) || (in_port == 3'(PORT_YN))
                  || (in_port == 3'(PORT_ZN));
        going_neg  = req[PORT_XN] | req[PORT_YN] | req[PORT_ZN];
        turn_err   = moving_pos & going_neg;
    end

endmodule

// File: rtl/nf_route_unit.sv
module nf_route_unit
    import nfr_pkg::*;
#(
    parameter int unsigned CW     = 2,
    parameter int unsigned MESH_X = 3,
    parameter int unsigned MESH_Y = 3,
    parameter int unsigned MESH_Z = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        my_x,
    input  logic [CW-1:0]        my_y,
    input  logic [CW-1:0]        my_z,
    input  logic [2:0]           in_port,
    input  logic                 flit_valid,
    input  logic                 flit_ready,
    input  logic                 flit_bop,
    input  logic                 flit_eop,
    input  logic [3*CW-1:0]      hdr_dst,
    output logic [NUM_PORTS-1:0] route_req,
    output logic                 turn_err
);
    localparam int unsigned MESH_SZ [NUM_DIMS] = '{MESH_X, MESH_Y, MESH_Z};

    logic [CW-1:0]       own_c [NUM_DIMS];
    logic [CW-1:0]       dst_c [NUM_DIMS];
    logic [NUM_DIMS-1:0] need_neg;
    logic [NUM_DIMS-1:0] need_pos;
    port_vec_t           fresh_req;
    logic                accept;
    logic                head_now;
    rc_state_t           state_d;
    rc_state_t           state_q;

    always_comb begin
        own_c[0] = my_x;
        own_c[1] = my_y;
        own_c[2] = my_z;
        for (int d = 0; d < NUM_DIMS; d++) begin
            dst_c[d] = hdr_dst[d*CW +: CW];
        end
    end

    for (genvar g = 0; g < NUM_DIMS; g++) begin : g_dim
        nfr_dim_cmp #(
            .CW   (CW),
            .MESH (MESH_SZ[g])
        ) u_cmp (
            .own_c    (own_c[g]),
            .dst_c    (dst_c[g]),
            .need_neg (need_neg[g]),
            .need_pos (need_pos[g])
        );
    end

    nfr_port_select u_sel (
        .need_neg (need_neg),
        .need_pos (need_pos),
        .req      (fresh_req)
    );

    always_comb begin
        accept   = flit_valid & flit_ready;
        head_now = flit_valid & flit_bop & ~state_q.busy;

        state_d = state_q;
        if (!state_q.busy) begin
            if (accept && flit_bop && !flit_eop) begin
                state_d.busy  = 1'b1;
                state_d.route = fresh_req;
            end
        end else if (accept && flit_eop) begin
            state_d.busy  = 1'b0;
            state_d.route = '0;
        end

        if (state_q.busy) begin
            route_req = state_q.route;
        end else if (head_now) begin
            route_req = fresh_req;
        end else begin
            route_req = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    nfr_turn_check u_turn (
        .in_port  (in_port),
        .req      (route_req),
        .turn_err (turn_err)
    );

endmodule

// File: rtl/nf_route_unit_chk.sv
module nf_route_unit_chk #(
    parameter int unsigned CW     = 2,
    parameter int unsigned MESH_X = 3,
    parameter int unsigned MESH_Y = 3,
    parameter int unsigned MESH_Z = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CW-1:0]   my_x,
    input logic [CW-1:0]   my_y,
    input logic [CW-1:0]   my_z,
    input logic            flit_valid,
    input logic            flit_ready,
    input logic            flit_bop,
    input logic            flit_eop,
    input logic [3*CW-1:0] hdr_dst,
    input logic [6:0]      route_req,
    input logic            busy
);
    logic [CW-1:0] dx, dy, dz;
    logic          head;

    always_comb begin
        dx   = hdr_dst[CW-1:0];
        dy   = hdr_dst[2*CW-1:CW];
        dz   = hdr_dst[3*CW-1:2*CW];
        head = flit_valid & flit_bop & ~busy;
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(route_req));

    a_r2_head_gives_req: assert property (@(posedge clk) disable iff (!rst_n)
        head |-> (route_req != 7'b0));

    a_r3_local_at_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (head && dx == my_x && dy == my_y && dz == my_z) |-> (route_req == 7'b0000001));

    a_r4_neg_before_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (head && (dx < my_x || dy < my_y || dz < my_z))
            |-> ((route_req & 7'b1010100) == 7'b0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(flit_valid && flit_ready && flit_eop)) |=> $stable(route_req));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flit_valid && flit_ready && flit_eop) |=> !busy);

    a_r9_no_edge_exit: assert property (@(posedge clk) disable iff (!rst_n)
        !((route_req[2] && my_x == CW'(MESH_X - 1))
       || (route_req[4] && my_y == CW'(MESH_Y - 1))
       || (route_req[6] && my_z == CW'(MESH_Z - 1))));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !flit_valid) |-> (route_req == 7'b0));

endmodule

bind nf_route_unit nf_route_unit_chk #(
    .CW     (CW),
    .MESH_X (MESH_X),
    .MESH_Y (MESH_Y),
    .MESH_Z (MESH_Z)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .my_x       (my_x),
    .my_y       (my_y),
    .my_z       (my_z),
    .flit_valid (flit_valid),
    .flit_ready (flit_ready),
    .flit_bop   (flit_bop),
    .flit_eop   (flit_eop),
    .hdr_dst    (hdr_dst),
    .route_req  (route_req),
    .busy       (state_q.busy)
);

// File: tb/nf_route_unit_tb_top.sv
module nf_route_unit_tb_top;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] my_x = '0, my_y = '0, my_z = '0;
    logic [2:0]    in_port = '0;
    logic          flit_valid = 1'b0, flit_ready = 1'b0;
    logic          flit_bop = 1'b0, flit_eop = 1'b0;
    logic [3*CW-1:0] hdr_dst = '0;
    logic [6:0]    route_req;
    logic          turn_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nf_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .my_z(my_z),
        .in_port(in_port), .flit_valid(flit_valid), .flit_ready(flit_ready),
        .flit_bop(flit_bop), .flit_eop(flit_eop), .hdr_dst(hdr_dst),
        .route_req(route_req), .turn_err(turn_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected port index from the requirement rules (mesh 3x3x3)
    function automatic int exp_port(input int o[3], input int d[3]);
        int neg_ord[3] = '{0, 2, 1};
        int pos_ord[3] = '{1, 0, 2};
        foreach (neg_ord[k]) if (d[neg_ord[k]] < o[neg_ord[k]]) return 1 + 2 * neg_ord[k];
        foreach (pos_ord[k]) if (d[pos_ord[k]] > o[pos_ord[k]] && o[pos_ord[k]] != 2)
            return 2 + 2 * pos_ord[k];
        return 0;
    endfunction

    task automatic present(input int o[3], input int d[3], input bit bop, input bit eop,
                           input bit rdy);
        @(negedge clk);
        my_x = CW'(o[0]); my_y = CW'(o[1]); my_z = CW'(o[2]);
        hdr_dst = {CW'(d[2]), CW'(d[1]), CW'(d[0])};
        flit_valid = 1'b1; flit_bop = bop; flit_eop = eop; flit_ready = rdy;
        #2;
    endtask

    task automatic go_idle();
        @(negedge clk);
        flit_valid = 1'b0; flit_bop = 1'b0; flit_eop = 1'b0; flit_ready = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        check("R11 reset route_req", route_req, 0);
        check("R11 reset turn_err", turn_err, 0);
    endtask

    task automatic t_orders();
        int o[3] = '{1, 1, 1};
        in_port = 3'd0;
        present(o, '{0, 2, 0}, 1, 1, 1); check("R5 -x first", route_req, 7'h02);
        present(o, '{1, 0, 0}, 1, 1, 1); check("R5 -z before -y", route_req, 7'h20);
        present(o, '{1, 0, 1}, 1, 1, 1); check("R5 -y alone", route_req, 7'h08);
        present(o, '{2, 0, 2}, 1, 1, 1); check("R4 negative before positive", route_req, 7'h08);
        present(o, '{2, 2, 2}, 1, 1, 1); check("R6 +y first", route_req, 7'h10);
        present(o, '{2, 1, 2}, 1, 1, 1); check("R6 +x before +z", route_req, 7'h04);
        present(o, '{1, 1, 2}, 1, 1, 1); check("R6 +z alone", route_req, 7'h40);
        present(o, '{1, 1, 1}, 1, 1, 1); check("R3 local", route_req, 7'h01);
        go_idle();
    endtask

    task automatic t_edges();
        in_port = 3'd0;
        present('{2, 1, 1}, '{3, 1, 1}, 1, 1, 1); check("R9 beyond +x edge", route_req, 7'h01);
        present('{2, 1, 1}, '{3, 0, 1}, 1, 1, 1); check("R9 skip x then -y", route_req, 7'h08);
        present('{2, 2, 2}, '{3, 3, 3}, 1, 1, 1); check("R9 corner", route_req, 7'h01);
        go_idle();
    endtask

    task automatic t_hold();
        int o[3] = '{1, 1, 1};
        in_port = 3'd0;
        present(o, '{2, 1, 1}, 1, 0, 1); check("R2 head route", route_req, 7'h04);
        present(o, '{0, 0, 0}, 1, 0, 1); check("R7 stray bop ignored", route_req, 7'h04);
        present(o, '{0, 0, 0}, 0, 1, 0); check("R7 stalled tail held", route_req, 7'h04);
        present(o, '{0, 0, 0}, 0, 1, 1); check("R7 tail accepted", route_req, 7'h04);
        go_idle();                       check("R7 released", route_req, 0);
        present(o, '{0, 1, 1}, 1, 1, 1); check("R8 single flit", route_req, 7'h02);
        present(o, '{2, 2, 2}, 0, 0, 1); check("R8 nothing held", route_req, 0);
        go_idle();
    endtask

    task automatic t_turn();
        int o[3] = '{1, 1, 1};
        in_port = 3'd1;
        present(o, '{1, 0, 1}, 1, 1, 1); check("R10 flag on +x to -y", turn_err, 1);
        present(o, '{1, 2, 1}, 1, 1, 1); check("R10 no flag on +y", turn_err, 0);
        in_port = 3'd2;
        present(o, '{1, 0, 1}, 1, 1, 1); check("R10 no flag from -x travel", turn_err, 0);
        in_port = 3'd0;
        go_idle();
    endtask

    task automatic t_all_pairs();
        for (int s = 0; s < 27; s++) begin
            for (int t = 0; t < 27; t++) begin
                int cur[3];
                int dst[3];
                int p;
                bit moved_pos = 0;
                bit arrived = 0;
                int hops = 0;
                cur = '{s % 3, (s / 3) % 3, s / 9};
                dst = '{t % 3, (t / 3) % 3, t / 9};
                in_port = 3'd0;
                while (!arrived && hops < 8) begin
                    present(cur, dst, 1, 1, 1);
                    p = exp_port(cur, dst);
                    check("R1 path hop port", route_req, 1 << p);
                    if (turn_err !== 1'b0) check("R10 path turn flag", turn_err, 0);
                    if (p == 0) begin
                        arrived = 1;
                    end else begin
                        if (p % 2 == 0) moved_pos = 1;
                        else if (moved_pos) check("R4 path positive then negative", p, 0);
                        cur[(p - 1) / 2] += (p % 2 == 0) ? 1 : -1;
                        in_port = 3'((p % 2 == 0) ? p - 1 : p + 1);
                        hops++;
                    end
                end
                check("R3 path reaches destination",
                      arrived && cur[0] == dst[0] && cur[1] == dst[1] && cur[2] == dst[2], 1);
            end
        end
        in_port = 3'd0;
        go_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_orders();
        t_edges();
        t_hold();
        t_turn();
        t_all_pairs();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule